// File: doc/BRIEF.md
# Byte-to-Word Video Port Bridge

This block lets an 8-bit processor reach the port block of a 16-bit video controller through a small 5-bit address window. The processor issues one read or write per cycle with an address, a strobe and a data byte. The bridge decodes the offset and does one of three things. It turns the access into a 16-bit access to the video data, control or test port. It sends the byte to a sound generator. Or it returns the matching byte lane of a 16-bit register: the data port, the control port or the horizontal/vertical position counter.

Reads and writes are decoded differently. Reads ignore address bit 1, so every readable port appears at two offsets. Writes ignore bits 1 and 0. For a write, the byte is copied into both halves of the 16-bit word. Some offsets are dead: a read there returns 0xFF and a write is dropped. Every other offset is illegal. An illegal access sets a sticky halt output, unless a force-acknowledge input is high at the time of the access. While halt is set, the bridge ignores the processor.

Behind the bridge sits a stub of the downstream devices. It holds the data and control words and a position counter that steps once for every write delivered downstream. This lets reads observe the effect of writes.

Top module: `vport_bridge`

## Requirements
- R1: After reset, `halt` is 0, `cpu_rdata` is 0xFF, no write strobe is high, and the stub holds data 0xC3A5, control 0x0312 and position counter 0x4B2D.
- R2: A read at offset 0x00 or 0x02 returns the data word's bits [15:8]; a read at 0x01 or 0x03 returns bits [7:0].
- R3: A read at 0x04 or 0x06 returns 0xFC ORed with control bits [9:8] in bits [1:0]; a read at 0x05 or 0x07 returns control bits [7:0].
- R4: Reads at 0x08, 0x0A, 0x0C, 0x0E return the position counter's bits [15:8]; reads at 0x09, 0x0B, 0x0D, 0x0F return its bits [7:0].
- R5: Reads at 0x18 to 0x1F return 0xFF and never set `halt`.
- R6: Reads at 0x10 to 0x17 return 0xFF and are illegal.
- R7: A write to 0x00–0x03 (data), 0x04–0x07 (control) or 0x1C–0x1F (test) raises the matching strobe for one cycle, with `port_wdata` = {byte, byte}. The strobe appears in the cycle after the request.
- R8: A write to an odd offset in 0x10–0x17 raises `snd_wr` for one cycle with `snd_data` = byte. A write to an even offset there is dropped without effect.
- R9: Writes to 0x18–0x1B are dropped without effect. Writes to 0x08–0x0F are illegal and raise no strobe.
- R10: An illegal access sets `halt` in the cycle after it, unless `force_ack` is 1 during that access. With `force_ack` at 1 the access is dropped (reads return 0xFF).
- R11: Once set, `halt` stays 1 until reset. While it is 1, reads and writes are ignored: no strobe is raised and `cpu_rdata` holds its value.
- R12: A delivered data or control write replaces the stub's data or control word. Every delivered write (data, control, test or sound) increments the position counter by one. Reads observe these changes from two cycles after the write request.
- R13: When `cpu_rd` and `cpu_wr` are both high, only the write is performed; `cpu_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 5 | Offset within the port window |
| cpu_rd | input | 1 | Read request, one access per high cycle |
| cpu_wr | input | 1 | Write request, one access per high cycle |
| cpu_wdata | input | 8 | Write byte |
| force_ack | input | 1 | Suppresses the halt on illegal access |
| cpu_rdata | output | 8 | Registered read byte |
| halt | output | 1 | Sticky lockup indication |
| port_wr_data | output | 1 | One-cycle data port write strobe |
| port_wr_ctrl | output | 1 | One-cycle control port write strobe |
| port_wr_test | output | 1 | One-cycle test port write strobe |
| port_wdata | output | 16 | Word sent with a port write strobe |
| snd_wr | output | 1 | One-cycle sound write strobe |
| snd_data | output | 8 | Byte sent with the sound strobe |

## Verification
Every processor-side result is registered once. Read data, the write strobes with their word or byte, and `halt` are all due in the cycle after the request, so the bench drives each request on a falling edge and samples one falling edge later. The stub registers take a delivered write on the edge after the strobe. For this reason each write task waits one more cycle before the next access, so a read-back sees the new word (R12). Halt persistence and the frozen read byte are checked over idle cycles and over ignored accesses after the halting access.

// File: rtl/vpb_pkg.sv
package vpb_pkg;

    parameter int unsigned BYTE_W = 8;
    parameter int unsigned WORD_W = 2 * BYTE_W;
    parameter int unsigned ADDR_W = 5;

    // read decode ignores bit 1, write decode ignores bits 1:0
    localparam logic [ADDR_W-1:0] RD_MASK = 5'h1D;
    localparam logic [ADDR_W-1:0] WR_MASK = 5'h1C;

    localparam logic [WORD_W-1:0] DATA_RST = 16'hC3A5;
    localparam logic [WORD_W-1:0] CTRL_RST = 16'h0312;
    localparam logic [WORD_W-1:0] HV_RST   = 16'h4B2D;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;
    localparam logic [BYTE_W-1:0] CTRL_HI_FILL = 8'hFC;

    typedef enum logic [3:0] {
        RS_DATA_HI,
        RS_DATA_LO,
        RS_CTRL_HI,
        RS_CTRL_LO,
        RS_HV_HI,
        RS_HV_LO,
        RS_DEAD,
        RS_ILLEGAL
    } rd_sel_e;

    typedef enum logic [2:0] {
        WS_DATA,
        WS_CTRL,
        WS_TEST,
        WS_SOUND,
        WS_DEAD,
        WS_ILLEGAL
    } wr_sel_e;

    // strobe vector bit positions
    localparam int unsigned STB_DATA = 0;
    localparam int unsigned STB_CTRL = 1;
    localparam int unsigned STB_TEST = 2;
    localparam int unsigned STB_SND  = 3;
    localparam int unsigned STB_N    = 4;

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
        logic              halt;
        logic [STB_N-1:0]  stb;
        logic [WORD_W-1:0] wword;
        logic [BYTE_W-1:0] sbyte;
    } bridge_st_t;

endpackage

// File: rtl/vpb_rd_dec.sv
module vpb_rd_dec
    import vpb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output rd_sel_e           sel
);
    logic [ADDR_W-1:0] key;

    always_comb begin
        key = addr & RD_MASK;
        unique case (key)
            5'h00:          sel = RS_DATA_HI;
            5'h01:          sel = RS_DATA_LO;
            5'h04:          sel = RS_CTRL_HI;
            5'h05:          sel = RS_CTRL_LO;
            5'h08, 5'h0C:   sel = RS_HV_HI;
            5'h09, 5'h0D:   sel = RS_HV_LO;
            5'h18, 5'h19,
            5'h1C, 5'h1D:   sel = RS_DEAD;
            default:        sel = RS_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/vpb_wr_dec.sv
module vpb_wr_dec
    import vpb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output wr_sel_e           sel
);
    logic [ADDR_W-1:0] key;

    always_comb begin
        key = addr & WR_MASK;
        unique case (key)
            5'h00:        sel = WS_DATA;
            5'h04:        sel = WS_CTRL;
            5'h10, 5'h14: sel = addr[0] ? WS_SOUND : WS_DEAD;
            5'h18:        sel = WS_DEAD;
            5'h1C:        sel = WS_TEST;
            default:      sel = WS_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/vpb_port_stub.sv
module vpb_port_stub
    import vpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STB_N-1:0]  stb,
    input  logic [WORD_W-1:0] wword,
    output logic [WORD_W-1:0] data_word,
    output logic [WORD_W-1:0] ctrl_word,
    output logic [WORD_W-1:0] hv_word
);
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] hv;
    } stub_st_t;

    stub_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb[STB_DATA]) st_d.data = wword;
        if (stb[STB_CTRL]) st_d.ctrl = wword;
        if (|stb)          st_d.hv   = st_q.hv + WORD_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data <= DATA_RST;
            st_q.ctrl <= CTRL_RST;
            st_q.hv   <= HV_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_word = st_q.data;
    assign ctrl_word = st_q.ctrl;
    assign hv_word   = st_q.hv;
endmodule

// File: rtl/vport_bridge.sv
module vport_bridge
    import vpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic              force_ack,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              halt,
    output logic              port_wr_data,
    output logic              port_wr_ctrl,
    output logic              port_wr_test,
    output logic [WORD_W-1:0] port_wdata,
    output logic              snd_wr,
    output logic [BYTE_W-1:0] snd_data
);
    rd_sel_e           rsel;
    wr_sel_e           wsel;
    logic [WORD_W-1:0] data_word, ctrl_word, hv_word;
    bridge_st_t        st_d, st_q;
    logic              rd_go, wr_go, bad_access;

    vpb_rd_dec u_rd_dec (.addr(cpu_addr), .sel(rsel));
    vpb_wr_dec u_wr_dec (.addr(cpu_addr), .sel(wsel));

    vpb_port_stub u_stub (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (st_q.stb),
        .wword     (st_q.wword),
        .data_word (data_word),
        .ctrl_word (ctrl_word),
        .hv_word   (hv_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.stb   = '0;
        bad_access = 1'b0;
        wr_go      = cpu_wr && !st_q.halt;
        rd_go      = cpu_rd && !cpu_wr && !st_q.halt;

        if (wr_go) begin
            unique case (wsel)
                WS_DATA: begin
                    st_d.stb[STB_DATA] = 1'b1;
                    st_d.wword = {cpu_wdata, cpu_wdata};
                end
                WS_CTRL: begin
                    st_d.stb[STB_CTRL] = 1'b1;
                    st_d.wword = {cpu_wdata, cpu_wdata};
                end
                WS_TEST: begin
                    st_d.stb[STB_TEST] = 1'b1;
                    st_d.wword = {cpu_wdata, cpu_wdata};
                end
                WS_SOUND: begin
                    st_d.stb[STB_SND] = 1'b1;
                    st_d.sbyte = cpu_wdata;
                end
                WS_ILLEGAL: bad_access = 1'b1;
                default: ;
            endcase
        end else if (rd_go) begin
            unique case (rsel)
                RS_DATA_HI: st_d.rdata = data_word[WORD_W-1:BYTE_W];
                RS_DATA_LO: st_d.rdata = data_word[BYTE_W-1:0];
                RS_CTRL_HI: st_d.rdata = CTRL_HI_FILL | {6'b0, ctrl_word[9:8]};
                RS_CTRL_LO: st_d.rdata = ctrl_word[BYTE_W-1:0];
                RS_HV_HI:   st_d.rdata = hv_word[WORD_W-1:BYTE_W];
                RS_HV_LO:   st_d.rdata = hv_word[BYTE_W-1:0];
                RS_ILLEGAL: begin
                    st_d.rdata = IDLE_BYTE;
                    bad_access = 1'b1;
                end
                default:    st_d.rdata = IDLE_BYTE;
            endcase
        end

        if (bad_access && !force_ack) st_d.halt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rdata <= IDLE_BYTE;
            st_q.halt  <= 1'b0;
            st_q.stb   <= '0;
            st_q.wword <= '0;
            st_q.sbyte <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_rdata    = st_q.rdata;
    assign halt         = st_q.halt;
    assign port_wr_data = st_q.stb[STB_DATA];
    assign port_wr_ctrl = st_q.stb[STB_CTRL];
    assign port_wr_test = st_q.stb[STB_TEST];
    assign snd_wr       = st_q.stb[STB_SND];
    assign port_wdata   = st_q.wword;
    assign snd_data     = st_q.sbyte;
endmodule

// File: rtl/vpb_checker.sv
module vpb_checker
    import vpb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              force_ack,
    input logic [BYTE_W-1:0] cpu_rdata,
    input logic              halt,
    input logic              port_wr_data,
    input logic              port_wr_ctrl,
    input logic              port_wr_test,
    input logic [WORD_W-1:0] port_wdata,
    input logic              snd_wr
);
    // R7: at most one downstream strobe per cycle
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({port_wr_data, port_wr_ctrl, port_wr_test, snd_wr}));

    // R7: port words carry the byte in both halves
    a_r7_replicated: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr_data || port_wr_ctrl || port_wr_test)
        |-> port_wdata[WORD_W-1:BYTE_W] == port_wdata[BYTE_W-1:0]);

    // R8: sound strobe only follows an odd-address write request
    a_r8_sound_odd: assert property (@(posedge clk) disable iff (!rst_n)
        snd_wr |-> ($past(cpu_wr) && $past(cpu_addr[0])));

    // R3: upper control byte is padded with ones
    a_r3_ctrl_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && !halt && ((cpu_addr & RD_MASK) == 5'h04))
        |=> cpu_rdata[7:2] == 6'h3F);

    // R10: illegal read without force-acknowledge halts
    a_r10_halt_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && !force_ack && cpu_addr[4:3] == 2'b10) |=> halt);

    // R11: halt is sticky
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    // R11: halted bridge raises no strobe and freezes read data
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!port_wr_data && !port_wr_ctrl && !port_wr_test && !snd_wr
                  && $stable(cpu_rdata)));

    // R13: combined request leaves read data untouched
    a_r13_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_wr) |=> $stable(cpu_rdata));
endmodule

bind vport_bridge vpb_checker u_vpb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_rd       (cpu_rd),
    .cpu_wr       (cpu_wr),
    .force_ack    (force_ack),
    .cpu_rdata    (cpu_rdata),
    .halt         (halt),
    .port_wr_data (port_wr_data),
    .port_wr_ctrl (port_wr_ctrl),
    .port_wr_test (port_wr_test),
    .port_wdata   (port_wdata),
    .snd_wr       (snd_wr)
);

// File: tb/tb_vport_bridge.sv
module tb_vport_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        force_ack = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        halt;
    logic        port_wr_data, port_wr_ctrl, port_wr_test, snd_wr;
    logic [15:0] port_wdata;
    logic [7:0]  snd_data;

    int n_chk = 0;
    int n_fail = 0;

    // bench model
    logic [15:0] m_data, m_ctrl, m_hv;
    logic [7:0]  m_rdata;
    logic        m_halt;

    always #5 clk = ~clk;

    vport_bridge dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .force_ack(force_ack),
        .cpu_rdata(cpu_rdata), .halt(halt), .port_wr_data(port_wr_data),
        .port_wr_ctrl(port_wr_ctrl), .port_wr_test(port_wr_test),
        .port_wdata(port_wdata), .snd_wr(snd_wr), .snd_data(snd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_data = 16'hC3A5; m_ctrl = 16'h0312; m_hv = 16'h4B2D;
        m_rdata = 8'hFF; m_halt = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; cpu_rd = 0; cpu_wr = 0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        model_reset();
    endtask

    // expected read byte and legality, from the read map
    function automatic logic [8:0] exp_read(input logic [4:0] a);
        logic [4:0] k;
        k = a & 5'h1D;
        case (k)
            5'h00: return {1'b0, m_data[15:8]};
            5'h01: return {1'b0, m_data[7:0]};
            5'h04: return {1'b0, 6'h3F, m_ctrl[9:8]};
            5'h05: return {1'b0, m_ctrl[7:0]};
            5'h08, 5'h0C: return {1'b0, m_hv[15:8]};
            5'h09, 5'h0D: return {1'b0, m_hv[7:0]};
            5'h18, 5'h19, 5'h1C, 5'h1D: return {1'b0, 8'hFF};
            default: return {1'b1, 8'hFF};
        endcase
    endfunction

    function automatic string rd_req(input logic [4:0] a);
        if (a < 5'h04) return "R2";
        if (a < 5'h08) return "R3";
        if (a < 5'h10) return "R4";
        if (a < 5'h18) return "R6";
        return "R5";
    endfunction

    task automatic do_rd(input logic [4:0] a, input string req);
        logic [8:0] e;
        e = exp_read(a);
        @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk); cpu_rd = 1'b0;
        if (!m_halt) begin
            m_rdata = e[7:0];
            if (e[8] && !force_ack) m_halt = 1'b1;
        end
        chk(req, cpu_rdata, m_rdata);
        chk(req, halt, m_halt);
    endtask

    // code: 0 data, 1 ctrl, 2 test, 3 sound, 4 dead, 5 illegal
    function automatic int wr_kind(input logic [4:0] a);
        case (a & 5'h1C)
            5'h00: return 0;
            5'h04: return 1;
            5'h1C: return 2;
            5'h10, 5'h14: return a[0] ? 3 : 4;
            5'h18: return 4;
            default: return 5;
        endcase
    endfunction

    task automatic do_wr(input logic [4:0] a, input logic [7:0] b, input logic also_rd, input string req);
        int k;
        k = m_halt ? 4 : wr_kind(a);
        @(negedge clk); cpu_addr = a; cpu_wdata = b; cpu_wr = 1'b1; cpu_rd = also_rd;
        @(negedge clk); cpu_wr = 1'b0; cpu_rd = 1'b0;
        if (k == 5 && !force_ack) m_halt = 1'b1;
        chk(req, {port_wr_data, port_wr_ctrl, port_wr_test, snd_wr},
            {k == 0, k == 1, k == 2, k == 3});
        if (k <= 2) chk(req, port_wdata, {b, b});
        if (k == 3) chk(req, snd_data, b);
        chk(req, halt, m_halt);
        chk(req, cpu_rdata, m_rdata);
        if (k == 0) m_data = {b, b};
        if (k == 1) m_ctrl = {b, b};
        if (k <= 3) m_hv = m_hv + 16'd1;
        @(negedge clk);
        chk(req, {port_wr_data, port_wr_ctrl, port_wr_test, snd_wr}, 4'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        // R1 reset state
        chk("R1", cpu_rdata, 8'hFF);
        chk("R1", halt, 1'b0);
        chk("R1", {port_wr_data, port_wr_ctrl, port_wr_test, snd_wr}, 4'b0);

        // read sweep, legal and illegal offsets, with force_ack (R2..R6, R10)
        force_ack = 1'b1;
        for (int a = 0; a < 32; a++) do_rd(5'(a), rd_req(5'(a)));

        // write sweep over every offset (R7, R8, R9, R10, R12)
        for (int a = 0; a < 32; a++) begin
            do_wr(5'(a), 8'(a * 37 + 9), 1'b0, (a >= 8 && a < 16) ? "R9" : "R7");
            for (int r = 0; r < 16; r++) do_rd(5'(r), "R12");
        end

        // patterns through data and control with read-back (R12, R3)
        foreach (m_rdata[i]) begin
            do_wr(5'h01, 8'h01 << i, 1'b0, "R7");
            do_rd(5'h02, "R12");
            do_wr(5'h06, ~(8'h01 << i), 1'b0, "R7");
            do_rd(5'h04, "R3");
            do_rd(5'h07, "R3");
            do_wr(5'h13, 8'hA0 | 8'(i), 1'b0, "R8");
            do_wr(5'h12, 8'h5A, 1'b0, "R8");
            do_rd(5'h0B, "R12");
        end

        // combined read and write (R13)
        do_rd(5'h00, "R13");
        do_wr(5'h05, 8'h3C, 1'b1, "R13");
        do_rd(5'h05, "R13");

        // illegal read without force halts (R10, R11)
        force_ack = 1'b0;
        do_rd(5'h1A, "R5");
        do_rd(5'h00, "R2");
        do_rd(5'h16, "R10");
        do_wr(5'h00, 8'h77, 1'b0, "R11");
        do_rd(5'h01, "R11");
        repeat (20) @(negedge clk);
        chk("R11", halt, 1'b1);
        chk("R11", cpu_rdata, 8'hFF);

        // reset clears, illegal write halts (R1, R9, R10)
        do_reset();
        chk("R1", halt, 1'b0);
        do_rd(5'h08, "R1");
        do_wr(5'h19, 8'h12, 1'b0, "R9");
        do_wr(5'h0E, 8'h34, 1'b0, "R10");
        do_wr(5'h1D, 8'h56, 1'b0, "R11");
        do_rd(5'h09, "R11");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule